// File: doc/BRIEF.md
# Ethernet Frame Pad and FCS Appender

This block sits in a byte-wide transmit datapath, between the logic that assembles a frame body and the logic that adds the preamble and drives the physical interface. A frame body is the destination address, source address, type field and payload. It arrives as a stream of bytes marked by valid and last, and the block sends it out unchanged one cycle later. When the body is shorter than the Ethernet minimum of 60 bytes, the block appends zero bytes until that minimum is reached. It then appends the four-byte frame check sequence, so every frame it emits is at least 64 bytes long.

The output is a byte with an enable flag, and it has no gaps within a frame. While the block is emitting pad and check bytes it holds `in_ready_o` low. It also holds it low for one idle cycle after each frame. The source must keep `in_valid_i` high from the first to the last byte of a body and may start the next body only when `in_ready_o` is high.

Top module: `eth_tx_finisher`

## Requirements
- R1: Each accepted body byte (`in_valid_i` and `in_ready_o` high at a clock edge) appears on `out_data_o` after that edge with `out_en_o` high, in arrival order and unmodified.
- R2: When a body has fewer than 60 bytes, zero bytes follow its last byte until body plus pad is exactly 60 bytes.
- R3: When a body has 60 or more bytes, no pad byte is inserted and the first check byte directly follows the last body byte.
- R4: The CRC uses polynomial 0x04C11DB7 and starts at all ones for every frame. It takes each byte least-significant bit first and covers every body and pad byte. As a result, the same CRC run over the emitted frame including its check bytes leaves the residue 0xC704DD7B in most-significant-first form.
- R5: Four check bytes follow, taken from the CRC register c held most-significant-first. Bit k of the first byte is ~c[31-k], of the second ~c[23-k], of the third ~c[15-k], and of the fourth ~c[7-k].
- R6: `out_en_o` stays high without a break from the first body byte through the last check byte, then stays low for at least one cycle. Every such run is at least 64 cycles long.
- R7: `in_ready_o` goes low in the cycle after the last body byte is accepted. It stays low through padding, the check bytes and one idle cycle. Bytes offered while it is low are ignored.
- R8: While `rst_ni` is low, `out_en_o` is low and `in_ready_o` is high. The CRC is returned to all ones, so a frame cut off by reset leaves no trace in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Body byte present |
| in_data_i | input | 8 | Body byte |
| in_last_i | input | 1 | Marks the final body byte |
| in_ready_o | output | 1 | Block will accept a body byte this cycle |
| out_en_o | output | 1 | Output byte enable |
| out_data_o | output | 8 | Output byte |

## Verification
The bench aims at body lengths on both sides of the 60-byte limit: 59, 60 and 61 bytes, plus very short bodies. A block with an off-by-one pad counter emits 63- or 65-byte frames or pads a frame that is already full size. Check bytes are compared with an independent reflected CRC model, and the residue over each whole emitted frame is checked as well. That catches a wrong seed, a wrong bit order or a swapped byte order, and a CRC that skips pad bytes or is not cleared between frames. Frames are sent back to back, and junk bytes are offered while the block is padding, so a missing idle cycle or a leaky ready shows up as merged or corrupted frames. A reset in the middle of a frame shows whether stale CRC state survives into the next frame.

// File: rtl/eth_fin_pkg.sv
package eth_fin_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;

  typedef enum logic [1:0] {
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } fin_state_e;

  // MSB-first register, data bits fed LSB first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/fin_crc.sv
module fin_crc
  import eth_fin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (clr_i)  crc_q <= CRC_SEED;
    else if (en_i)   crc_q <= crc_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/fin_fcs_sel.sv
module fin_fcs_sel
  import eth_fin_pkg::*;
#(
  parameter int unsigned NBYTES = FCS_BYTES,
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [NBYTES*BYTE_W-1:0] crc_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [BYTE_W-1:0]        byte_o
);
  logic [BYTE_W-1:0] lane [NBYTES];
  logic [BYTE_W-1:0] sel;
  logic [IDX_W-1:0]  lane_idx;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane[b] = crc_i[b*BYTE_W +: BYTE_W];
  end

  // first emitted byte comes from the top lane
  assign lane_idx = IDX_W'(NBYTES - 1) - idx_i;
  assign sel      = lane[lane_idx];

  for (genvar k = 0; k < BYTE_W; k++) begin : g_rev
    assign byte_o[k] = ~sel[BYTE_W-1-k];
  end
endmodule

// File: rtl/fin_ctrl.sv
module fin_ctrl
  import eth_fin_pkg::*;
#(
  parameter int unsigned MIN_BODY = 60,
  parameter int unsigned NFCS     = FCS_BYTES,
  localparam int unsigned CNT_W   = $clog2(MIN_BODY + 1),
  localparam int unsigned IDX_W   = (NFCS > 1) ? $clog2(NFCS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             ready_o,
  output logic             take_o,
  output logic             pad_o,
  output logic             fcs_o,
  output logic [IDX_W-1:0] fcs_idx_o,
  output logic             clr_o
);
  fin_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             full;

  assign ready_o = (state_q == ST_BODY);
  assign take_o  = ready_o && in_valid_i;
  assign pad_o   = (state_q == ST_PAD);
  assign fcs_o   = (state_q == ST_FCS);
  assign clr_o   = (state_q == ST_GAP);
  assign fcs_idx_o = idx_q;

  // saturating length count, only the minimum matters
  assign cnt_inc = (cnt_q == CNT_W'(MIN_BODY)) ? cnt_q : cnt_q + 1'b1;
  assign full    = (cnt_inc == CNT_W'(MIN_BODY));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_BODY: if (take_o) begin
        cnt_d = cnt_inc;
        idx_d = '0;
        if (in_last_i) state_d = full ? ST_FCS : ST_PAD;
      end
      ST_PAD: begin
        cnt_d = cnt_inc;
        if (full) state_d = ST_FCS;
      end
      ST_FCS: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(NFCS - 1)) state_d = ST_GAP;
      end
      ST_GAP: begin
        cnt_d   = '0;
        state_d = ST_BODY;
      end
      default: state_d = ST_BODY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BODY;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/eth_tx_finisher.sv
module eth_tx_finisher
  import eth_fin_pkg::*;
#(
  parameter int unsigned MIN_BODY = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_en_o,
  output logic [BYTE_W-1:0] out_data_o
);
  localparam int unsigned IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

  logic              take, pad, fcs, clr;
  logic [IDX_W-1:0]  fcs_idx;
  logic [CRC_W-1:0]  crc;
  logic [BYTE_W-1:0] crc_byte, fcs_byte;
  logic              out_en_q;
  logic [BYTE_W-1:0] out_data_q;

  fin_ctrl #(.MIN_BODY(MIN_BODY), .NFCS(FCS_BYTES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .in_last_i (in_last_i),
    .ready_o   (in_ready_o),
    .take_o    (take),
    .pad_o     (pad),
    .fcs_o     (fcs),
    .fcs_idx_o (fcs_idx),
    .clr_o     (clr)
  );

  assign crc_byte = pad ? '0 : in_data_i;

  fin_crc u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .en_i  (take | pad),
    .byte_i(crc_byte),
    .crc_o (crc)
  );

  fin_fcs_sel #(.NBYTES(FCS_BYTES)) u_sel (
    .crc_i (crc),
    .idx_i (fcs_idx),
    .byte_o(fcs_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_en_q   <= 1'b0;
      out_data_q <= '0;
    end else begin
      out_en_q   <= take | pad | fcs;
      out_data_q <= take ? in_data_i : (fcs ? fcs_byte : '0);
    end
  end

  assign out_en_o   = out_en_q;
  assign out_data_o = out_data_q;
endmodule

// File: rtl/eth_tx_finisher_chk.sv
module eth_tx_finisher_chk #(
  parameter int unsigned MIN_FRAME = 64,
  localparam int unsigned RUN_W    = $clog2(MIN_FRAME + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       in_last_i,
  input logic       in_ready_o,
  input logic       out_en_o,
  input logic [7:0] out_data_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (!out_en_o) run_q <= '0;
    else if (run_q != RUN_W'(MIN_FRAME)) run_q <= run_q + 1'b1;
  end

  assert_body_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_en_o && out_data_o == $past(in_data_i)));

  assert_run_starts_body_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $past(in_valid_i && in_ready_o));

  assert_run_min_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_en_o) |-> (run_q == RUN_W'(MIN_FRAME)));

  assert_ready_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o);

  assert_reset_idle_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_en_o && in_ready_o));
endmodule

bind eth_tx_finisher eth_tx_finisher_chk #(.MIN_FRAME(MIN_BODY + eth_fin_pkg::FCS_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .in_valid_i(in_valid_i),
  .in_data_i (in_data_i),
  .in_last_i (in_last_i),
  .in_ready_o(in_ready_o),
  .out_en_o  (out_en_o),
  .out_data_o(out_data_o)
);

// File: tb/eth_tx_finisher_bench.sv
`timescale 1ns/1ps
module eth_tx_finisher_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready_o, out_en_o;
  logic [7:0] out_data_o;

  always #2 clk = ~clk;

  eth_tx_finisher u_eth_tx_finisher (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid),
    .in_data_i (in_data),
    .in_last_i (in_last),
    .in_ready_o(in_ready_o),
    .out_en_o  (out_en_o),
    .out_data_o(out_data_o)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  seed;
    logic [15:0] exp_len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd14,  8'd3,  16'd64},
    '{16'd15,  8'd7,  16'd64},
    '{16'd45,  8'd11, 16'd64},
    '{16'd59,  8'd19, 16'd64},
    '{16'd60,  8'd23, 16'd64},
    '{16'd61,  8'd29, 16'd65},
    '{16'd100, 8'd31, 16'd104},
    '{16'd64,  8'd37, 16'd68}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] cap [0:2047];
  int         cap_n = 0;
  int         runs  = 0;
  logic       prev_en = 1'b0;
  logic [7:0] fr [0:255];

  always @(negedge clk) begin
    if (out_en_o === 1'b1 && cap_n < 2048) begin
      cap[cap_n] = out_data_o;
      cap_n++;
    end
    if (prev_en && !out_en_o) runs++;
    prev_en = out_en_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] bitrev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [7:0] gen_byte(input int s, input int j);
    return 8'((s * 31 + j * 17 + (j >> 2)) ^ 8'h5C);
  endfunction

  task automatic run_frame(input int len, input int seed, input bit junk, input int exp_len);
    int base, r0, n, pad_n, bad;
    logic [31:0] c;
    for (int j = 0; j < len; j++) fr[j] = gen_byte(seed, j);
    while (!in_ready_o) @(negedge clk);
    base = cap_n;
    r0   = runs;
    for (int j = 0; j < len; j++) begin
      in_valid = 1'b1;
      in_data  = fr[j];
      in_last  = (j == len - 1);
      @(negedge clk);
    end
    if (junk) begin
      chk(in_ready_o == 1'b0, "R7", "ready after last", longint'(in_ready_o), 0);
      while (!in_ready_o) begin
        in_valid = 1'b1;
        in_data  = 8'hA5;
        in_last  = 1'b1;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_data  = '0;
    while (runs == r0) @(negedge clk);

    n = cap_n - base;
    chk(n == exp_len, "R6", "continuous frame length", n, exp_len);
    if (len >= 60) chk(n == len + 4, "R3", "no pad on full-size body", n, len + 4);
    bad = 0;
    for (int j = 0; j < len; j++) if (cap[base + j] !== fr[j]) bad++;
    chk(bad == 0, "R1", "body byte mismatches", bad, 0);
    pad_n = (len < 60) ? 60 - len : 0;
    bad = 0;
    for (int j = 0; j < pad_n; j++) if (cap[base + len + j] !== 8'h00) bad++;
    chk(bad == 0, "R2", "nonzero pad bytes", bad, 0);
    c = '1;
    for (int j = 0; j < len; j++) c = ref_crc(c, fr[j]);
    for (int j = 0; j < pad_n; j++) c = ref_crc(c, 8'h00);
    c = ~c;
    for (int b = 0; b < 4; b++)
      chk(cap[base + len + pad_n + b] === c[8*b +: 8], "R5", "check byte",
          cap[base + len + pad_n + b], c[8*b +: 8]);
    c = '1;
    for (int j = 0; j < n; j++) c = ref_crc(c, cap[base + j]);
    chk(bitrev32(c) == 32'hC704_DD7B, "R4", "frame residue", bitrev32(c), 32'hC704_DD7B);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_en_o == 1'b0, "R8", "enable in reset", out_en_o, 0);
    chk(in_ready_o == 1'b1, "R8", "ready in reset", in_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_en_o == 1'b0, "R8", "enable after reset", out_en_o, 0);

    for (int v = 0; v < 8; v++)
      run_frame(int'(VECS[v].len), int'(VECS[v].seed), 1'b0, int'(VECS[v].exp_len));

    // junk offered while padding and sending the check bytes (R7)
    run_frame(20, 41, 1'b1, 64);
    run_frame(70, 43, 1'b1, 74);

    // reset mid-frame, then a clean frame (R8)
    for (int j = 0; j < 10; j++) begin
      in_valid = 1'b1;
      in_data  = gen_byte(47, j);
      in_last  = 1'b0;
      @(negedge clk);
    end
    rst_ni   = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_en_o == 1'b0, "R8", "enable after mid-frame reset", out_en_o, 0);
    chk(in_ready_o == 1'b1, "R8", "ready after mid-frame reset", in_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    run_frame(61, 53, 1'b0, 65);
    run_frame(1, 59, 1'b0, 64);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule